// File: doc/BRIEF.md
# Write-Protected Transmitter Control with Line Flush Sequencer

This block holds the control word for a serial transmitter core. It has two live bits: one holds the core in reset and one requests a line flush. A write changes the word only when its upper byte carries a fixed unlock value in the same write. The unlock value is never stored, so every change needs a write that carries it again. The other bits are kept at zero, and the whole word can be read back.

A flush request starts a short sequence on the transmit side. Both data lanes go high for one cycle while the transmit clock is held. The transmit clock is then enabled for five cycles with the lanes held high. After that the lanes drop back to idle low. A busy output covers the whole sequence. A flush starts only on the 0-to-1 change of the request bit, and only while the core is out of reset. Putting the core into reset during a flush stops it at once.

The testbench runs on one clock for both the bus side and the transmit side.

Top module: `txc_ctrl`

## Requirements
- R1: A write with wr_en high and wr_data[15:8] equal to 8'hA5 loads wr_data[0] into the core-reset bit and wr_data[1] into the flush bit, visible on rd_data from the next cycle.
- R2: A write whose wr_data[15:8] differs from 8'hA5 leaves the whole control word unchanged. The unlock value is not remembered between writes.
- R3: rd_data[15:2] always reads 0. This covers the write-only unlock field and the reserved bits 7:2, and writes to those bits have no effect.
- R4: After reset, rd_data is 16'h0000, core_rst_o is 0, and txd_o, txclk_en_o and flush_busy_o are all 0.
- R5: core_rst_o equals the core-reset bit (rd_data[0]).
- R6: When the flush bit changes 0 to 1 with core reset at 0, the cycle after the change shows txd_o all ones with txclk_en_o at 0. The next five cycles show txclk_en_o at 1 with txd_o all ones. Then txd_o and txclk_en_o return to 0.
- R7: flush_busy_o is high for exactly the six pattern cycles (the toggle cycle plus five clock cycles) and low otherwise.
- R8: A flush bit held at 1 after the pattern ends does not start a new one. The next flush needs the bit cleared and then set again.
- R9: A flush bit set while core reset is 1 does not start the pattern, and clearing core reset afterwards does not start it either.
- R10: When core reset becomes 1 during a flush, txd_o, txclk_en_o and flush_busy_o read 0 from that same cycle, and the pattern is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the sequencer |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data: unlock byte in 15:8, flush in bit 1, core reset in bit 0 |
| rd_data | output | 16 | Read-back of the control word |
| core_rst_o | output | 1 | Holds the transmitter core in reset while high |
| txd_o | output | NUM_LANES | Data lanes driven by the flush pattern |
| txclk_en_o | output | 1 | Transmit clock enable during the flush pattern |
| flush_busy_o | output | 1 | High while the flush pattern runs |

## Verification
The assertions assume that wr_en and wr_data change only between clock edges. They also assume that flush requests come from software, so the pattern length is measured only when a flush ends naturally and not when core reset aborts it. The stimulus is driven on the falling edge, so writes are always whole and single-cycle. Flush requests are separated by clearing writes, and the abort is issued partway through a running pattern. This lets both the natural end and the forced end be observed.

// File: rtl/txc_pkg.sv
package txc_pkg;

    localparam int          REG_W        = 16;
    localparam int          KEY_LSB      = 8;
    localparam int          KEY_W        = REG_W - KEY_LSB;
    localparam logic [KEY_W-1:0] UNLOCK_VAL = 8'hA5;
    localparam int          BIT_CORE_RST = 0;
    localparam int          BIT_FLUSH    = 1;

    typedef struct packed {
        logic flush;
        logic core_rst;
    } txc_ctrl_t;

    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_TOGGLE = 2'd1,
        FL_CLOCKS = 2'd2
    } fl_state_e;

    typedef struct packed {
        logic lanes_on;
        logic clk_on;
        logic busy;
    } fl_drive_t;

    function automatic logic unlock_ok(input logic [REG_W-1:0] d);
        return d[REG_W-1:KEY_LSB] == UNLOCK_VAL;
    endfunction

    function automatic txc_ctrl_t decode_ctrl(input logic [REG_W-1:0] d);
        txc_ctrl_t c;
        c.flush    = d[BIT_FLUSH];
        c.core_rst = d[BIT_CORE_RST];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_readback(input txc_ctrl_t c);
        logic [REG_W-1:0] r;
        r               = '0;
        r[BIT_FLUSH]    = c.flush;
        r[BIT_CORE_RST] = c.core_rst;
        return r;
    endfunction

    function automatic fl_drive_t drive_of(input fl_state_e s);
        fl_drive_t d;
        d.lanes_on = (s != FL_IDLE);
        d.clk_on   = (s == FL_CLOCKS);
        d.busy     = (s != FL_IDLE);
        return d;
    endfunction

endpackage

// File: rtl/txc_key_reg.sv
module txc_key_reg
    import txc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output txc_ctrl_t        ctrl_o,
    output logic [REG_W-1:0] rd_data_o
);

    txc_ctrl_t ctrl_q;
    logic      accept;

    assign accept = wr_en && unlock_ok(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= decode_ctrl(wr_data);
        end
    end

    assign ctrl_o    = ctrl_q;
    assign rd_data_o = pack_readback(ctrl_q);

endmodule

// File: rtl/txc_flush_seq.sv
module txc_flush_seq
    import txc_pkg::*;
#(
    parameter int FLUSH_CLKS = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush_req,
    input  logic      hold_rst,
    output fl_drive_t drive_o
);

    localparam int CW = $clog2(FLUSH_CLKS + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(FLUSH_CLKS - 1);

    fl_state_e     state_q;
    fl_state_e     state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          req_prev_q;
    logic          start;

    assign start = flush_req && !req_prev_q && !hold_rst;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (hold_rst) begin
            state_d = FL_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FL_IDLE: begin
                    if (start) begin
                        state_d = FL_TOGGLE;
                    end
                end
                FL_TOGGLE: begin
                    state_d = FL_CLOCKS;
                    cnt_d   = CNT_LOAD;
                end
                FL_CLOCKS: begin
                    if (cnt_q == '0) begin
                        state_d = FL_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = FL_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FL_IDLE;
            cnt_q      <= '0;
            req_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            req_prev_q <= flush_req;
        end
    end

    assign drive_o = drive_of(state_q);

endmodule

// File: rtl/txc_out_gate.sv
module txc_out_gate
    import txc_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  fl_drive_t             drive_i,
    input  logic                  hold_rst,
    output logic [NUM_LANES-1:0]  txd_o,
    output logic                  clk_en_o,
    output logic                  busy_o
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign txd_o[g] = drive_i.lanes_on && !hold_rst;
    end

    assign clk_en_o = drive_i.clk_on && !hold_rst;
    assign busy_o   = drive_i.busy && !hold_rst;

endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl
    import txc_pkg::*;
#(
    parameter int NUM_LANES  = 2,
    parameter int FLUSH_CLKS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    output logic                 core_rst_o,
    output logic [NUM_LANES-1:0] txd_o,
    output logic                 txclk_en_o,
    output logic                 flush_busy_o
);

    txc_ctrl_t ctrl;
    fl_drive_t drive;

    txc_key_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctrl_o    (ctrl),
        .rd_data_o (rd_data)
    );

    txc_flush_seq #(.FLUSH_CLKS(FLUSH_CLKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .flush_req (ctrl.flush),
        .hold_rst  (ctrl.core_rst),
        .drive_o   (drive)
    );

    txc_out_gate #(.NUM_LANES(NUM_LANES)) u_gate (
        .drive_i  (drive),
        .hold_rst (ctrl.core_rst),
        .txd_o    (txd_o),
        .clk_en_o (txclk_en_o),
        .busy_o   (flush_busy_o)
    );

    assign core_rst_o = ctrl.core_rst;

endmodule

// File: rtl/txc_ctrl_chk.sv
module txc_ctrl_chk #(
    parameter int NUM_LANES  = 2,
    parameter int FLUSH_CLKS = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [15:0]          wr_data,
    input logic [15:0]          rd_data,
    input logic                 core_rst_o,
    input logic [NUM_LANES-1:0] txd_o,
    input logic                 txclk_en_o,
    input logic                 flush_busy_o
);

    localparam int BW = $clog2(FLUSH_CLKS + 3);

    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !flush_busy_o) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_GOOD_KEY_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[15:8] == 8'hA5) |=> rd_data[1:0] == $past(wr_data[1:0])); // R1

    AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[15:8] != 8'hA5) |=> $stable(rd_data)); // R2

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[15:2] == 14'd0); // R3

    AST_TOGGLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_busy_o) |-> (!txclk_en_o && txd_o == {NUM_LANES{1'b1}})); // R6

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        ($fell(flush_busy_o) && !core_rst_o) |-> busy_cnt == BW'(FLUSH_CLKS + 1)); // R7

    AST_START_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_busy_o) |-> ($past(rd_data[1]) && !core_rst_o)); // R9

    AST_RST_SILENCES: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> (txd_o == '0 && !txclk_en_o && !flush_busy_o)); // R10

endmodule

bind txc_ctrl txc_ctrl_chk #(.NUM_LANES(NUM_LANES), .FLUSH_CLKS(FLUSH_CLKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .core_rst_o   (core_rst_o),
    .txd_o        (txd_o),
    .txclk_en_o   (txclk_en_o),
    .flush_busy_o (flush_busy_o)
);

// File: tb/txc_ctrl_tb.sv
module txc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 2;
    localparam int NV         = 8;

    localparam logic [31:0] VEC [NV] = '{
        {16'hA501, 16'h0001},
        {16'h5A00, 16'h0001},
        {16'hA5FC, 16'h0000},
        {16'h0003, 16'h0000},
        {16'hA503, 16'h0003},
        {16'hA5FF, 16'h0003},
        {16'hA400, 16'h0003},
        {16'hA500, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;
    logic          core_rst_o;
    logic [NL-1:0] txd_o;
    logic          txclk_en_o;
    logic          flush_busy_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txc_ctrl #(.NUM_LANES(NL), .FLUSH_CLKS(5)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .core_rst_o   (core_rst_o),
        .txd_o        (txd_o),
        .txclk_en_o   (txclk_en_o),
        .flush_busy_o (flush_busy_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] outs();
        return {28'd0, flush_busy_o, txclk_en_o, txd_o};
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step();
        check("R4 rd_data", rd_data, 0);
        check("R4 outputs", {core_rst_o, outs()}, 0);

        // table walk: R1 R2 R3 R5
        for (int i = 0; i < NV; i++) begin
            write(VEC[i][31:16]);
            check("R1/R2/R3 rd_data", rd_data, VEC[i][15:0]);
            check("R5 core_rst_o", core_rst_o, VEC[i][0]);
        end
        repeat (10) step();

        // R6 R7 pattern
        write(16'hA502);
        check("R7 not yet busy", outs(), 0);
        step();
        check("R6 toggle cycle", outs(), {28'd0, 1'b1, 1'b0, 2'b11});
        for (int c = 0; c < 5; c++) begin
            step();
            check("R6 clock cycle", outs(), {28'd0, 1'b1, 1'b1, 2'b11});
        end
        step();
        check("R7 idle after pattern", outs(), 0);

        // R8 held bit does not retrigger
        for (int c = 0; c < 8; c++) begin
            step();
            check("R8 held no retrigger", outs(), 0);
        end
        write(16'hA500);
        write(16'hA502);
        step();
        check("R8 re-armed toggle", outs(), {28'd0, 1'b1, 1'b0, 2'b11});
        repeat (7) step();
        write(16'hA500);

        // R9 flush while in reset
        write(16'hA501);
        write(16'hA503);
        for (int c = 0; c < 4; c++) begin
            step();
            check("R9 no flush in reset", outs(), 0);
        end
        write(16'hA502);
        check("R9 reset released", rd_data, 16'h0002);
        for (int c = 0; c < 8; c++) begin
            step();
            check("R9 no late start", outs(), 0);
        end
        write(16'hA500);

        // R10 abort
        write(16'hA502);
        repeat (3) step();
        check("R10 running before abort", outs(), {28'd0, 1'b1, 1'b1, 2'b11});
        write(16'hA503);
        check("R10 abort same cycle", outs(), 0);
        for (int c = 0; c < 3; c++) begin
            step();
            check("R10 stays idle", outs(), 0);
        end
        write(16'hA500);
        for (int c = 0; c < 8; c++) begin
            step();
            check("R10 no resume", outs(), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule